// File: doc/BRIEF.md
# Peripheral Register Bit-Field Access Unit

This unit lets a small coprocessor read or change a field of bits inside a 32-bit peripheral register without touching the rest of that register. A request names the register by its word address, gives the upper and lower bit indices of the field, and for a write carries an 8-bit immediate. A field read returns the selected bits right-aligned and zero-extended into a 16-bit result for the coprocessor's accumulator. A field write reads the register over the bus, replaces only the selected bits, and writes the merged word back.

The register bus is a simple synchronous one. A one-cycle read strobe returns data on the following cycle, and a one-cycle write strobe carries the full word. Word addresses count 32-bit registers. Software that knows a register's byte address derives the word address by subtracting the peripheral base and dividing by four. Every operation takes a fixed number of cycles: a read uses 4 execute plus 4 fetch cycles, and a write uses 8 execute plus 4 fetch cycles. The last of these cycles carries a one-cycle done pulse.

The sequencer has six states. `FA_IDLE` accepts a request and moves to `FA_RD_ISSUE`, which drives the bus read. `FA_RD_ISSUE` always moves to `FA_RD_CAPTURE`, which latches the returned word. From `FA_RD_CAPTURE` a legal write goes to `FA_WR_ISSUE`, which drives the bus write. Any other operation goes from `FA_RD_CAPTURE` to `FA_PAD`, and `FA_WR_ISSUE` also always moves to `FA_PAD`. `FA_PAD` waits until the cycle count reaches the operation's total less two, then moves to `FA_FINISH`. `FA_FINISH` pulses done and returns to `FA_IDLE`.

Top module: `fieldacc_unit`

## Requirements
- R1: Each bus read and bus write of an operation drives `bus_addr` with the word address latched from `req_addr` when the request was accepted, and `bus_addr` holds steady while the operation runs.
- R2: A read with `req_hi >= req_lo` returns bits hi down to lo of the addressed register in `res_data`, with the field's lowest bit at `res_data[0]` and all bits above the field zero. For example, hi=7 and lo=4 on 0x1234ABCD gives 0x000C.
- R3: When a read field is wider than 16 bits, `res_data` holds the 16 lowest bits of the field.
- R4: A write with `req_hi >= req_lo` performs exactly one bus read and then, two cycles later, exactly one bus write to the same address. The written word equals the word read, with bits hi down to lo replaced and every other bit unchanged.
- R5: Immediate bits at positions at or above the field width are dropped. Field bits above bit 7 of the immediate are written as zero.
- R6: A request with `req_hi < req_lo` is illegal. It still makes one bus read but never a bus write. A read of this kind sets `res_data` to 0.
- R7: Counting the cycle after the accepting clock edge as cycle 1, `done` is high only in cycle 8 for a read and only in cycle 12 for a write, for exactly one cycle.
- R8: A request presented while an operation is in progress is ignored. It causes no bus access and does not change the result.
- R9: After reset the unit is idle, with `done`, `bus_rd` and `bus_wr` low and `res_data` zero.
- R10: `bus_rd` and `bus_wr` are never high in the same cycle. A field write leaves `res_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation strobe, sampled while idle |
| req_write | input | 1 | 1 = field write, 0 = field read |
| req_addr | input | ADDR_W | Register word address |
| req_hi | input | 5 | Upper bit index of the field |
| req_lo | input | 5 | Lower bit index of the field |
| req_imm | input | 8 | Immediate data for writes |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 16 | Zero-extended read result |
| bus_addr | output | ADDR_W | Bus word address |
| bus_rd | output | 1 | Bus read strobe; data returns next cycle |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |

## Verification
A wrong sequencer state shows at the ports within a cycle or two. A skipped `FA_RD_CAPTURE` writes back stale data in the very next bus write. A wrong pad length moves the `done` pulse off its cycle, and a missed return to idle swallows the next request, so no bus read appears one cycle after the strobe. Errors in the mask or shift show up only in the contents of a register: they stay invisible until that register is read back over the bus, and the bench reads the stand-in memory after every write to catch them.

// File: rtl/fa_pkg.sv
package fa_pkg;

    typedef enum logic [2:0] {
        FA_IDLE       = 3'd0,
        FA_RD_ISSUE   = 3'd1,
        FA_RD_CAPTURE = 3'd2,
        FA_WR_ISSUE   = 3'd3,
        FA_PAD        = 3'd4,
        FA_FINISH     = 3'd5
    } fa_state_e;

endpackage

// File: rtl/fa_mask_gen.sv
module fa_mask_gen #(
    parameter int REG_W  = 32,
    parameter int FIDX_W = $clog2(REG_W)
) (
    input  logic [FIDX_W-1:0] hi,
    input  logic [FIDX_W-1:0] lo,
    output logic [REG_W-1:0]  mask,
    output logic              field_bad
);
    localparam logic [FIDX_W-1:0] TOP_IDX = FIDX_W'(REG_W - 1);

    logic [REG_W-1:0] from_lo;
    logic [REG_W-1:0] to_hi;

    always_comb begin
        field_bad = (hi < lo);
        from_lo   = {REG_W{1'b1}} << lo;
        to_hi     = {REG_W{1'b1}} >> (TOP_IDX - hi);
        mask      = field_bad ? '0 : (from_lo & to_hi);
    end
endmodule

// File: rtl/fa_field_extract.sv
module fa_field_extract #(
    parameter int REG_W  = 32,
    parameter int RES_W  = 16,
    parameter int FIDX_W = $clog2(REG_W)
) (
    input  logic [REG_W-1:0]  word,
    input  logic [REG_W-1:0]  mask,
    input  logic [FIDX_W-1:0] lo,
    output logic [RES_W-1:0]  field
);
    always_comb begin
        field = RES_W'((word & mask) >> lo);
    end
endmodule

// File: rtl/fa_field_merge.sv
module fa_field_merge #(
    parameter int REG_W  = 32,
    parameter int IMM_W  = 8,
    parameter int FIDX_W = $clog2(REG_W)
) (
    input  logic [REG_W-1:0]  word,
    input  logic [REG_W-1:0]  mask,
    input  logic [FIDX_W-1:0] lo,
    input  logic [IMM_W-1:0]  imm,
    output logic [REG_W-1:0]  merged
);
    logic [REG_W-1:0] imm_wide;
    logic [REG_W-1:0] imm_placed;

    always_comb begin
        imm_wide   = {{(REG_W-IMM_W){1'b0}}, imm};
        imm_placed = (imm_wide << lo) & mask;
        merged     = (word & ~mask) | imm_placed;
    end
endmodule

// File: rtl/fa_seq.sv
module fa_seq
    import fa_pkg::*;
#(
    parameter int RD_TOTAL = 8,
    parameter int WR_TOTAL = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic field_bad,
    output logic accept,
    output logic rd_strobe,
    output logic wr_strobe,
    output logic capture,
    output logic finish,
    output logic busy,
    output logic op_write
);
    localparam int MAX_TOTAL = (RD_TOTAL > WR_TOTAL) ? RD_TOTAL : WR_TOTAL;
    localparam int CNT_W     = $clog2(MAX_TOTAL + 1);
    localparam logic [CNT_W-1:0] RD_PAD_END = CNT_W'(RD_TOTAL - 2);
    localparam logic [CNT_W-1:0] WR_PAD_END = CNT_W'(WR_TOTAL - 2);

    fa_state_e        state_q, state_d;
    logic [CNT_W-1:0] cyc_q;
    logic             op_write_q;
    logic [CNT_W-1:0] pad_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FA_IDLE;
            cyc_q      <= '0;
            op_write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cyc_q      <= '0;
                op_write_q <= req_write;
            end else if (state_q != FA_IDLE) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        pad_end = op_write_q ? WR_PAD_END : RD_PAD_END;
        state_d = state_q;
        unique case (state_q)
            FA_IDLE:       if (req_valid) state_d = FA_RD_ISSUE;
            FA_RD_ISSUE:   state_d = FA_RD_CAPTURE;
            FA_RD_CAPTURE: state_d = (op_write_q && !field_bad) ? FA_WR_ISSUE : FA_PAD;
            FA_WR_ISSUE:   state_d = FA_PAD;
            FA_PAD:        if (cyc_q == pad_end) state_d = FA_FINISH;
            FA_FINISH:     state_d = FA_IDLE;
            default:       state_d = FA_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = (state_q == FA_IDLE) && req_valid;
        rd_strobe = (state_q == FA_RD_ISSUE);
        capture   = (state_q == FA_RD_CAPTURE);
        wr_strobe = (state_q == FA_WR_ISSUE);
        finish    = (state_q == FA_FINISH);
        busy      = (state_q != FA_IDLE);
        op_write  = op_write_q;
    end
endmodule

// File: rtl/fieldacc_unit.sv
module fieldacc_unit #(
    parameter int ADDR_W    = 8,
    parameter int REG_W     = 32,
    parameter int RES_W     = 16,
    parameter int IMM_W     = 8,
    parameter int RD_EXEC   = 4,
    parameter int WR_EXEC   = 8,
    parameter int FETCH_CYC = 4,
    parameter int FIDX_W    = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FIDX_W-1:0] req_hi,
    input  logic [FIDX_W-1:0] req_lo,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              done,
    output logic [RES_W-1:0]  res_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  bus_rdata
);
    localparam int RD_TOTAL = RD_EXEC + FETCH_CYC;
    localparam int WR_TOTAL = WR_EXEC + FETCH_CYC;

    logic              accept, capture, busy_w, op_write, field_bad;
    logic [ADDR_W-1:0] addr_q;
    logic [FIDX_W-1:0] hi_q, lo_q;
    logic [IMM_W-1:0]  imm_q;
    logic [REG_W-1:0]  word_q;
    logic [RES_W-1:0]  res_q;
    logic [REG_W-1:0]  mask;
    logic [RES_W-1:0]  field_rd;
    logic [REG_W-1:0]  merged;

    fa_seq #(
        .RD_TOTAL(RD_TOTAL),
        .WR_TOTAL(WR_TOTAL)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .field_bad(field_bad),
        .accept   (accept),
        .rd_strobe(bus_rd),
        .wr_strobe(bus_wr),
        .capture  (capture),
        .finish   (done),
        .busy     (busy_w),
        .op_write (op_write)
    );

    fa_mask_gen #(.REG_W(REG_W), .FIDX_W(FIDX_W)) u_mask (
        .hi       (hi_q),
        .lo       (lo_q),
        .mask     (mask),
        .field_bad(field_bad)
    );

    fa_field_extract #(.REG_W(REG_W), .RES_W(RES_W), .FIDX_W(FIDX_W)) u_extract (
        .word (bus_rdata),
        .mask (mask),
        .lo   (lo_q),
        .field(field_rd)
    );

    fa_field_merge #(.REG_W(REG_W), .IMM_W(IMM_W), .FIDX_W(FIDX_W)) u_merge (
        .word  (word_q),
        .mask  (mask),
        .lo    (lo_q),
        .imm   (imm_q),
        .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            imm_q  <= '0;
            word_q <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                hi_q   <= req_hi;
                lo_q   <= req_lo;
                imm_q  <= req_imm;
            end
            if (capture) begin
                word_q <= bus_rdata;
                if (!op_write) res_q <= field_bad ? '0 : field_rd;
            end
        end
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = merged;
    assign res_data  = res_q;
endmodule

// File: rtl/fieldacc_unit_chk.sv
module fieldacc_unit_chk #(
    parameter int ADDR_W   = 8,
    parameter int FIDX_W   = 5,
    parameter int RD_TOTAL = 8,
    parameter int WR_TOTAL = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FIDX_W-1:0] hi_q,
    input logic [FIDX_W-1:0] lo_q
);
    localparam int CNT_W = $clog2(RD_TOTAL + WR_TOTAL + 1);
    logic [CNT_W-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n) busy_len <= '0;
        else        busy_len <= busy ? busy_len + 1'b1 : '0;
    end

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_len == CNT_W'(RD_TOTAL - 1) || busy_len == CNT_W'(WR_TOTAL - 1)));

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r8_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> bus_rd);

    a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr));

    a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd, 2));

    a_r6_no_illegal_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (hi_q >= lo_q));

    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));
endmodule

bind fieldacc_unit fieldacc_unit_chk #(
    .ADDR_W  (ADDR_W),
    .FIDX_W  (FIDX_W),
    .RD_TOTAL(RD_EXEC + FETCH_CYC),
    .WR_TOTAL(WR_EXEC + FETCH_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .done    (done),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .hi_q    (hi_q),
    .lo_q    (lo_q)
);

// File: tb/fieldacc_unit_tb_top.sv
`timescale 1ns/1ps
module fieldacc_unit_tb_top;
    localparam int ADDR_W = 8;
    localparam int RD_CYC = 8;
    localparam int WR_CYC = 12;
    localparam int NVEC   = 14;

    // {write, addr, hi, lo, imm, expected}: expected is res_data for reads,
    // the resulting register word for writes
    localparam logic [58:0] VECS [NVEC] = '{
        {1'b0, 8'd3, 5'd7,  5'd4,  8'h00, 32'h0000_000C},
        {1'b0, 8'd3, 5'd31, 5'd16, 8'h00, 32'h0000_1234},
        {1'b0, 8'd3, 5'd15, 5'd0,  8'h00, 32'h0000_ABCD},
        {1'b0, 8'd9, 5'd31, 5'd0,  8'h00, 32'h0000_BEEF},
        {1'b0, 8'd3, 5'd3,  5'd3,  8'h00, 32'h0000_0001},
        {1'b1, 8'd7, 5'd11, 5'd4,  8'hA5, 32'h0000_0A50},
        {1'b1, 8'd5, 5'd3,  5'd0,  8'hF2, 32'hFFFF_FFF2},
        {1'b1, 8'd5, 5'd31, 5'd24, 8'h00, 32'h00FF_FFF2},
        {1'b1, 8'd7, 5'd19, 5'd8,  8'hFF, 32'h0000_FF50},
        {1'b0, 8'd7, 5'd15, 5'd8,  8'h00, 32'h0000_00FF},
        {1'b1, 8'd9, 5'd2,  5'd6,  8'hFF, 32'hDEAD_BEEF},
        {1'b0, 8'd9, 5'd0,  5'd4,  8'h00, 32'h0000_0000},
        {1'b1, 8'd9, 5'd31, 5'd31, 8'h00, 32'h5EAD_BEEF},
        {1'b0, 8'd9, 5'd31, 5'd28, 8'h00, 32'h0000_0005}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [4:0]        req_hi, req_lo;
    logic [7:0]        req_imm;
    logic              done;
    logic [15:0]       res_data;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_rd, bus_wr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata = '0;

    logic [31:0] mem [256];
    int rd_cnt = 0, wr_cnt = 0;
    logic [ADDR_W-1:0] last_rd_addr = '0, last_wr_addr = '0;
    int n_chk = 0, n_fail = 0;

    fieldacc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_hi(req_hi), .req_lo(req_lo), .req_imm(req_imm),
        .done(done), .res_data(res_data), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // stand-in peripheral registers
    always @(posedge clk) begin
        if (bus_rd) begin
            bus_rdata    <= mem[bus_addr];
            rd_cnt       <= rd_cnt + 1;
            last_rd_addr <= bus_addr;
        end
        if (bus_wr) begin
            mem[bus_addr] <= bus_wdata;
            wr_cnt        <= wr_cnt + 1;
            last_wr_addr  <= bus_addr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic [7:0] addr, input logic [4:0] hi,
                          input logic [4:0] lo, input logic [7:0] imm);
        int total;
        int done_bad;
        total = wr ? WR_CYC : RD_CYC;
        done_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_hi = hi; req_lo = lo; req_imm = imm;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            if (done !== (i == total - 1)) done_bad++;
        end
        chk("R7 done only in final cycle", 32'(done_bad), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_hi = '0; req_lo = '0; req_imm = '0;
        for (int a = 0; a < 256; a++) mem[a] = '0;
        mem[3] = 32'h1234_ABCD;
        mem[5] = 32'hFFFF_FFFF;
        mem[9] = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset done", 32'(done), 32'd0);
        chk("R9 reset bus_rd", 32'(bus_rd), 32'd0);
        chk("R9 reset bus_wr", 32'(bus_wr), 32'd0);
        chk("R9 reset res_data", 32'(res_data), 32'd0);
        rst_n = 1'b1;

        // vector table: R2 R3 R4 R5 R6 R1 R10
        for (int v = 0; v < NVEC; v++) begin
            logic [58:0] e;
            int rd0, wr0;
            logic [15:0] res0;
            e = VECS[v];
            rd0 = rd_cnt; wr0 = wr_cnt; res0 = res_data;
            run_op(e[58], e[57:50], e[49:45], e[44:40], e[39:32]);
            chk("R1 R4 R6 one bus read", 32'(rd_cnt - rd0), 32'd1);
            chk("R1 read address", 32'(last_rd_addr), 32'(e[57:50]));
            if (e[58]) begin
                chk("R4 R5 R6 write count", 32'(wr_cnt - wr0), (e[49:45] >= e[44:40]) ? 32'd1 : 32'd0);
                chk("R4 R5 R6 register word", mem[e[57:50]], e[31:0]);
                chk("R10 write keeps res_data", 32'(res_data), 32'(res0));
                if (e[49:45] >= e[44:40])
                    chk("R1 write address", 32'(last_wr_addr), 32'(e[57:50]));
            end else begin
                chk("R2 R3 R6 read result", 32'(res_data), e[31:0]);
                chk("R2 read makes no write", 32'(wr_cnt - wr0), 32'd0);
            end
        end

        // R8: requests during an operation are ignored
        begin
            int rd0, wr0;
            rd0 = rd_cnt; wr0 = wr_cnt;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd3;
            req_hi = 5'd15; req_lo = 5'd0; req_imm = '0;
            for (int i = 0; i < RD_CYC; i++) begin
                @(negedge clk);
                if (i == 0) begin
                    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd5;
                    req_hi = 5'd7; req_lo = 5'd0; req_imm = 8'h11;
                end
                if (i == 4) req_valid = 1'b0;
            end
            chk("R8 done at end of first op", 32'(done), 32'd1);
            @(negedge clk);
            chk("R8 only one bus read", 32'(rd_cnt - rd0), 32'd1);
            chk("R8 no bus write", 32'(wr_cnt - wr0), 32'd0);
            chk("R8 register untouched", mem[5], 32'h00FF_FFF2);
            chk("R8 result of first op", 32'(res_data), 32'h0000_ABCD);
        end

        // R9: reset in mid-operation returns to idle
        run_op(1'b0, 8'd3, 5'd7, 5'd4, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd3;
        req_hi = 5'd7; req_lo = 5'd0; req_imm = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int wr0;
            wr0 = wr_cnt;
            chk("R9 reset clears result", 32'(res_data), 32'd0);
            repeat (WR_CYC) @(negedge clk);
            chk("R9 aborted op never writes", 32'(wr_cnt - wr0), 32'd0);
            chk("R9 no done after reset", 32'(done), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule